// File: doc/BRIEF.md
# Receive Buffer Read-Port Auto-Clear Controller

This block sits beside the receive buffer of one selected pipe while a DMA engine drains it through a read port. When a packet is written into the buffer, the protocol side pulses a packet-end event together with the reason the packet stopped and the number of bytes it left behind. The block holds that reason, counts down the remaining bytes as DMA read strobes arrive, and advances a read pointer.

Once the data is gone, the block decides who empties the buffer. The decision uses three things: whether automatic clearing is enabled, which buffer-ready mode is selected, and why the packet ended. In one case the block pulses an automatic clear and returns to idle by itself. In another it releases the buffer with no action. In the third it raises a clear-request flag and waits for a software clear strobe. A DMA transfer-end strobe can optionally be used to mark the read as complete before the byte count reaches zero.

Top module: `rxbuf_autoclr`

## Requirements
- R1: While reset is asserted, every output is zero: buffer idle, no cause held, count and pointer zero, no clear pulse, no clear request.
- R2: Packet acceptance.
  - A packet-end pulse taken while the block is idle does the following at the next edge: it loads the byte count with the packet length (clamped to MAX_PKT), sets the read pointer to zero, latches the cause, and asserts buf_valid_o and cause_vld_o.
  - The cause encoding is 0 for buffer full, 1 for zero-length, 2 for short packet and 3 for transaction count reached.
  - A packet-end pulse that arrives while the block is not idle is ignored.
- R3: Read strobes.
  - Each read strobe taken while the buffer is valid and not yet drained consumes one beat.
  - The beat size depends on the transfer size code: code 0 is 1 byte, code 1 is 2 bytes, code 2 is 4 bytes and code 3 is 16 bytes.
  - The count never goes below zero. The read pointer advances by the number of bytes actually consumed.
- R4: With automatic clearing not in effect, a clear request is raised at the edge that accepts the packet in these cases:
  - a zero-length packet, in either buffer-ready mode;
  - a short packet or a reached transaction count, only when the buffer-ready mode is 1.
  - A buffer-full packet never raises a clear request.
- R5: Automatic clearing is in effect when it is enabled and the direction is read. In that case:
  - No cause ever raises a clear request.
  - When the buffer is drained, auto_clr_o is high for exactly one cycle.
  - At the following edge the count, the pointer and the held cause are cleared and the block is idle.
  - A read strobe in the pulse cycle has no effect.
- R6: In the write direction (dir_read_i = 0), the automatic-clear enable has no effect. The block behaves exactly as with the enable off, and auto_clr_o never rises.
- R7: The transfer-end strobe can mark the buffer drained whatever count remains. This happens when transfer-end sampling is enabled and the transfer size code is not 3.
- R8: When the transfer size code is 3, the transfer-end strobe is ignored even if sampling is enabled.
- R9: A drained buffer with a clear request pending goes to a hold state. In hold, buf_valid_o is low, the cause stays held, and read strobes are ignored until software clears it. A drained buffer with no request pending returns to idle with no pulse.
- R10: The software clear strobe takes priority over every other input. From any state, at the next edge the block is idle and the flag, count, pointer and held cause are all zero. A packet-end pulse in the same cycle is ignored.
- R11: The held cause does not change while cause_vld_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_read_i | input | 1 | 1 = buffer read direction (buffer to DMA) |
| auto_clr_en_i | input | 1 | Automatic clear enable |
| rdy_mode_i | input | 1 | Buffer-ready mode select |
| xend_en_i | input | 1 | Enable sampling of the DMA transfer-end strobe |
| xfer_size_i | input | 2 | DMA transfer size code (0:1B, 1:2B, 2:4B, 3:16B) |
| pkt_end_i | input | 1 | Packet-end event pulse |
| pkt_cause_i | input | 2 | Packet termination cause (0 full, 1 zero-length, 2 short, 3 count reached) |
| pkt_bytes_i | input | CNT_W | Bytes held by the packet |
| rd_stb_i | input | 1 | DMA read strobe |
| dma_xend_i | input | 1 | DMA transfer-end strobe |
| sw_clr_i | input | 1 | Software buffer clear strobe |
| buf_valid_o | output | 1 | Buffer holds unread data |
| cause_vld_o | output | 1 | A termination cause is held |
| cause_o | output | 2 | Held termination cause |
| byte_cnt_o | output | CNT_W | Remaining bytes |
| rd_ptr_o | output | CNT_W | Read pointer |
| auto_clr_o | output | 1 | One-cycle automatic clear pulse |
| clr_req_o | output | 1 | Clear-required flag for software |

## Verification
The main function is swept over all 32 combinations of cause, buffer-ready mode, auto-clear enable and direction. Each combination uses a packet length fitted to its cause and a transfer size that rotates across the case index. Comparing outcomes across this sweep separates the three possible endings: automatic pulse, silent release, and hold with request. The sweep also shows that the write direction behaves like auto-clear off. Directed sequences add the remaining cases:
- a packet end that arrives while busy,
- a transfer-end strobe with the 16-byte size and with smaller sizes,
- a read strobe in the same cycle as the automatic pulse,
- a software clear that collides with a packet end.

// File: rtl/rxbuf_ac_pkg.sv
package rxbuf_ac_pkg;

  typedef enum logic [1:0] {
    CAUSE_FULL  = 2'd0,
    CAUSE_ZLP   = 2'd1,
    CAUSE_SHORT = 2'd2,
    CAUSE_TCNT  = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    XS_1B  = 2'd0,
    XS_2B  = 2'd1,
    XS_4B  = 2'd2,
    XS_16B = 2'd3
  } xsize_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILLED = 2'd1,
    ST_HOLD   = 2'd2
  } state_e;

  localparam int unsigned BEAT_W = 5;

  function automatic logic [BEAT_W-1:0] beat_bytes(input logic [1:0] code);
    case (code)
      XS_1B:   beat_bytes = 5'd1;
      XS_2B:   beat_bytes = 5'd2;
      XS_4B:   beat_bytes = 5'd4;
      default: beat_bytes = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/rxbuf_ac_decide.sv
module rxbuf_ac_decide
  import rxbuf_ac_pkg::*;
(
  input  logic       dir_read_i,
  input  logic       auto_clr_en_i,
  input  logic       rdy_mode_i,
  input  logic [1:0] cause_i,
  input  logic       xend_en_i,
  input  logic [1:0] xfer_size_i,
  input  logic       dma_xend_i,
  output logic       auto_eff_o,
  output logic       need_clr_o,
  output logic       xend_hit_o
);

  logic is_zlp, is_short_or_cnt;

  // auto clear only meaningful when draining toward DMA
  assign auto_eff_o = auto_clr_en_i & dir_read_i;

  assign is_zlp          = (cause_i == CAUSE_ZLP);
  assign is_short_or_cnt = (cause_i == CAUSE_SHORT) || (cause_i == CAUSE_TCNT);

  always_comb begin
    need_clr_o = 1'b0;
    if (!auto_eff_o) begin
      if (is_zlp)                       need_clr_o = 1'b1;
      else if (is_short_or_cnt && rdy_mode_i) need_clr_o = 1'b1;
    end
  end

  // 16-byte transfers cannot use end sampling
  assign xend_hit_o = xend_en_i & dma_xend_i & (xfer_size_i != XS_16B);

endmodule

// File: rtl/rxbuf_ac_drain.sv
module rxbuf_ac_drain
  import rxbuf_ac_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  input  logic             consume_i,
  input  logic [1:0]       size_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] ptr_o,
  output logic             empty_o
);

  localparam int unsigned XW = CNT_W + BEAT_W;

  logic [CNT_W-1:0] cnt_q, ptr_q, take;
  logic [XW-1:0]    beat_x, cnt_x;

  assign beat_x = {{CNT_W{1'b0}}, beat_bytes(size_i)};
  assign cnt_x  = {{BEAT_W{1'b0}}, cnt_q};
  assign take   = (beat_x < cnt_x) ? beat_x[CNT_W-1:0] : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ptr_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
      ptr_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_cnt_i;
      ptr_q <= '0;
    end else if (consume_i) begin
      cnt_q <= cnt_q - take;
      ptr_q <= ptr_q + take;
    end
  end

  assign cnt_o   = cnt_q;
  assign ptr_o   = ptr_q;
  assign empty_o = (cnt_q == '0);

endmodule

// File: rtl/rxbuf_autoclr.sv
module rxbuf_autoclr
  import rxbuf_ac_pkg::*;
#(
  parameter int unsigned MAX_PKT = 64,
  localparam int unsigned CNT_W  = $clog2(MAX_PKT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_read_i,
  input  logic             auto_clr_en_i,
  input  logic             rdy_mode_i,
  input  logic             xend_en_i,
  input  logic [1:0]       xfer_size_i,
  input  logic             pkt_end_i,
  input  logic [1:0]       pkt_cause_i,
  input  logic [CNT_W-1:0] pkt_bytes_i,
  input  logic             rd_stb_i,
  input  logic             dma_xend_i,
  input  logic             sw_clr_i,
  output logic             buf_valid_o,
  output logic             cause_vld_o,
  output logic [1:0]       cause_o,
  output logic [CNT_W-1:0] byte_cnt_o,
  output logic [CNT_W-1:0] rd_ptr_o,
  output logic             auto_clr_o,
  output logic             clr_req_o
);

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_PKT);

  state_e           state_q, state_d;
  logic [1:0]       cause_q;
  logic             clr_req_q;
  logic             auto_eff, need_clr, xend_hit;
  logic             accept, drained, release_buf, drain_clear, consume, empty;
  logic [CNT_W-1:0] load_cnt;

  rxbuf_ac_decide u_decide (
    .dir_read_i    (dir_read_i),
    .auto_clr_en_i (auto_clr_en_i),
    .rdy_mode_i    (rdy_mode_i),
    .cause_i       (pkt_cause_i),
    .xend_en_i     (xend_en_i),
    .xfer_size_i   (xfer_size_i),
    .dma_xend_i    (dma_xend_i),
    .auto_eff_o    (auto_eff),
    .need_clr_o    (need_clr),
    .xend_hit_o    (xend_hit)
  );

  assign load_cnt = (pkt_bytes_i > MAX_CNT) ? MAX_CNT : pkt_bytes_i;

  assign accept      = pkt_end_i && (state_q == ST_IDLE) && !sw_clr_i;
  assign drained     = (state_q == ST_FILLED) && (empty || xend_hit);
  // pending request forces hold; otherwise buffer goes back to idle
  assign release_buf = drained && !clr_req_q && !sw_clr_i;
  assign drain_clear = sw_clr_i || release_buf;
  assign consume     = rd_stb_i && (state_q == ST_FILLED) && !drained && !sw_clr_i;

  rxbuf_ac_drain #(.CNT_W(CNT_W)) u_drain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (drain_clear),
    .load_i     (accept),
    .load_cnt_i (load_cnt),
    .consume_i  (consume),
    .size_i     (xfer_size_i),
    .cnt_o      (byte_cnt_o),
    .ptr_o      (rd_ptr_o),
    .empty_o    (empty)
  );

  always_comb begin
    state_d = state_q;
    if (sw_clr_i) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:   if (accept) state_d = ST_FILLED;
        ST_FILLED: if (drained) state_d = clr_req_q ? ST_HOLD : ST_IDLE;
        ST_HOLD:   state_d = ST_HOLD;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cause_q   <= '0;
      clr_req_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (sw_clr_i || release_buf) cause_q <= '0;
      else if (accept)             cause_q <= pkt_cause_i;
      if (sw_clr_i)                clr_req_q <= 1'b0;
      else if (accept && need_clr) clr_req_q <= 1'b1;
    end
  end

  assign buf_valid_o = (state_q == ST_FILLED);
  assign cause_vld_o = (state_q != ST_IDLE);
  assign cause_o     = cause_q;
  assign auto_clr_o  = release_buf && auto_eff;
  assign clr_req_o   = clr_req_q;

endmodule

// File: rtl/rxbuf_autoclr_chk.sv
module rxbuf_autoclr_chk #(
  parameter int unsigned MAX_PKT = 64,
  localparam int unsigned CNT_W  = $clog2(MAX_PKT + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dir_read_i,
  input logic             auto_clr_en_i,
  input logic             pkt_end_i,
  input logic             sw_clr_i,
  input logic             buf_valid_o,
  input logic             cause_vld_o,
  input logic [1:0]       cause_o,
  input logic [CNT_W-1:0] byte_cnt_o,
  input logic [CNT_W-1:0] rd_ptr_o,
  input logic             auto_clr_o,
  input logic             clr_req_o
);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_cnt_o <= CNT_W'(MAX_PKT)); // R2

  AST_FULL_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cause_vld_o) && cause_o == 2'd0) |-> !clr_req_o); // R4

  AST_ZLP_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cause_vld_o) && cause_o == 2'd1 && !$past(auto_clr_en_i && dir_read_i))
      |-> clr_req_o); // R4

  AST_AUTO_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cause_vld_o) && $past(pkt_end_i && auto_clr_en_i && dir_read_i))
      |-> !clr_req_o); // R5

  AST_AUTO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_clr_o |=> (!auto_clr_o && !cause_vld_o && byte_cnt_o == '0 && rd_ptr_o == '0)); // R5

  AST_NO_AUTO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_read_i |-> !auto_clr_o); // R6

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_req_o && !sw_clr_i) |=> clr_req_o); // R9

  AST_REQ_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_req_o |-> cause_vld_o); // R9

  AST_VALID_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_valid_o |-> cause_vld_o); // R2

  AST_SW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_clr_i |=> (!clr_req_o && !cause_vld_o && byte_cnt_o == '0 && rd_ptr_o == '0)); // R10

  AST_CAUSE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_vld_o |=> (!cause_vld_o || $stable(cause_o))); // R11

endmodule

bind rxbuf_autoclr rxbuf_autoclr_chk #(.MAX_PKT(MAX_PKT)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .dir_read_i    (dir_read_i),
  .auto_clr_en_i (auto_clr_en_i),
  .pkt_end_i     (pkt_end_i),
  .sw_clr_i      (sw_clr_i),
  .buf_valid_o   (buf_valid_o),
  .cause_vld_o   (cause_vld_o),
  .cause_o       (cause_o),
  .byte_cnt_o    (byte_cnt_o),
  .rd_ptr_o      (rd_ptr_o),
  .auto_clr_o    (auto_clr_o),
  .clr_req_o     (clr_req_o)
);

// File: tb/rxbuf_autoclr_tb_top.sv
module rxbuf_autoclr_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_PKT    = 64;
  localparam int CW         = $clog2(MAX_PKT + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          dir_read_i = 1'b0, auto_clr_en_i = 1'b0, rdy_mode_i = 1'b0, xend_en_i = 1'b0;
  logic [1:0]    xfer_size_i = '0, pkt_cause_i = '0;
  logic          pkt_end_i = 1'b0, rd_stb_i = 1'b0, dma_xend_i = 1'b0, sw_clr_i = 1'b0;
  logic [CW-1:0] pkt_bytes_i = '0;
  logic          buf_valid_o, cause_vld_o, auto_clr_o, clr_req_o;
  logic [1:0]    cause_o;
  logic [CW-1:0] byte_cnt_o, rd_ptr_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rxbuf_autoclr #(.MAX_PKT(MAX_PKT)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .dir_read_i(dir_read_i), .auto_clr_en_i(auto_clr_en_i),
    .rdy_mode_i(rdy_mode_i), .xend_en_i(xend_en_i), .xfer_size_i(xfer_size_i),
    .pkt_end_i(pkt_end_i), .pkt_cause_i(pkt_cause_i), .pkt_bytes_i(pkt_bytes_i),
    .rd_stb_i(rd_stb_i), .dma_xend_i(dma_xend_i), .sw_clr_i(sw_clr_i),
    .buf_valid_o(buf_valid_o), .cause_vld_o(cause_vld_o), .cause_o(cause_o),
    .byte_cnt_o(byte_cnt_o), .rd_ptr_o(rd_ptr_o), .auto_clr_o(auto_clr_o), .clr_req_o(clr_req_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    #2;
  endtask

  function automatic int beat(input int s);
    return (s == 0) ? 1 : (s == 1) ? 2 : (s == 2) ? 4 : 16;
  endfunction

  task automatic load(input int c, input int b);
    pkt_cause_i = c[1:0];
    pkt_bytes_i = b[CW-1:0];
    pkt_end_i   = 1'b1;
    cyc();
    pkt_end_i   = 1'b0;
  endtask

  task automatic swclr();
    sw_clr_i = 1'b1;
    cyc();
    sw_clr_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #2;
    // R1 reset state
    check("R1 buf_valid", buf_valid_o, 0);
    check("R1 cause_vld", cause_vld_o, 0);
    check("R1 byte_cnt", int'(byte_cnt_o), 0);
    check("R1 rd_ptr", int'(rd_ptr_o), 0);
    check("R1 auto_clr", auto_clr_o, 0);
    check("R1 clr_req", clr_req_o, 0);
    rst_ni = 1'b1;
    cyc();

    for (int a = 0; a < 2; a++)
      for (int d = 0; d < 2; d++)
        for (int m = 0; m < 2; m++)
          for (int c = 0; c < 4; c++) begin
            int ae, rq, b, s, nrd;
            string tag;
            ae  = a & d;
            rq  = (!ae && (c == 1 || (m == 1 && c >= 2))) ? 1 : 0;
            b   = (c == 0) ? MAX_PKT : (c == 1) ? 0 : (c == 2) ? 13 : 40;
            s   = (a * 8 + d * 4 + m * 2 + c) % 4;
            nrd = (b + beat(s) - 1) / beat(s);
            tag = ae ? "R5" : ((a == 1 && d == 0) ? "R6" : "R4");
            auto_clr_en_i = a[0]; dir_read_i = d[0]; rdy_mode_i = m[0]; xfer_size_i = s[1:0];
            load(c, b);
            check("R2 cause", int'(cause_o), c);
            check("R2 byte_cnt", int'(byte_cnt_o), b);
            check({tag, " clr_req"}, clr_req_o, rq);
            for (int k = 0; k < nrd; k++) begin
              rd_stb_i = 1'b1;
              cyc();
            end
            rd_stb_i = 1'b0;
            check("R3 rd_ptr", int'(rd_ptr_o), b);
            check("R3 byte_cnt", int'(byte_cnt_o), 0);
            #1;
            check({tag, " auto_clr"}, auto_clr_o, (ae && !rq) ? 1 : 0);
            cyc();
            if (rq != 0) begin
              check("R9 hold cause_vld", cause_vld_o, 1);
              check("R9 hold buf_valid", buf_valid_o, 0);
              rd_stb_i = 1'b1;
              cyc();
              rd_stb_i = 1'b0;
              check("R9 hold clr_req", clr_req_o, 1);
              check("R11 cause held", int'(cause_o), c);
              swclr();
              check("R10 clr_req", clr_req_o, 0);
              check("R10 cause_vld", cause_vld_o, 0);
            end else begin
              check("R9 release cause_vld", cause_vld_o, 0);
              check("R5 cnt after drain", int'(byte_cnt_o), 0);
              check("R5 ptr after drain", int'(rd_ptr_o), 0);
            end
          end

    // R2: packet end while busy is ignored
    auto_clr_en_i = 1'b0; dir_read_i = 1'b1; rdy_mode_i = 1'b0; xfer_size_i = 2'd0;
    load(2, 5);
    load(1, 0);
    check("R2 busy ignored cnt", int'(byte_cnt_o), 5);
    check("R2 busy ignored cause", int'(cause_o), 2);
    swclr();

    // R7 with auto: transfer end drains early, read strobe in pulse cycle ignored (R5)
    auto_clr_en_i = 1'b1; xend_en_i = 1'b1; xfer_size_i = 2'd0;
    load(3, 30);
    dma_xend_i = 1'b1; rd_stb_i = 1'b1;
    #1;
    check("R7 auto_clr on xend", auto_clr_o, 1);
    cyc();
    dma_xend_i = 1'b0; rd_stb_i = 1'b0;
    check("R5 cnt after pulse", int'(byte_cnt_o), 0);
    check("R5 ptr after pulse", int'(rd_ptr_o), 0);
    check("R5 idle after pulse", cause_vld_o, 0);

    // R8: 16-byte size ignores transfer end
    xfer_size_i = 2'd3;
    load(2, 20);
    dma_xend_i = 1'b1;
    #1;
    check("R8 no auto_clr", auto_clr_o, 0);
    cyc();
    dma_xend_i = 1'b0;
    check("R8 cnt kept", int'(byte_cnt_o), 20);
    check("R8 still valid", buf_valid_o, 1);
    rd_stb_i = 1'b1;
    cyc();
    rd_stb_i = 1'b0;
    check("R3 16B beat", int'(byte_cnt_o), 4);
    check("R3 16B ptr", int'(rd_ptr_o), 16);
    swclr();
    check("R10 cnt", int'(byte_cnt_o), 0);
    check("R10 ptr", int'(rd_ptr_o), 0);

    // R10: software clear wins over packet end
    sw_clr_i = 1'b1; pkt_end_i = 1'b1; pkt_cause_i = 2'd2; pkt_bytes_i = CW'(7);
    cyc();
    sw_clr_i = 1'b0; pkt_end_i = 1'b0;
    check("R10 collide cause_vld", cause_vld_o, 0);
    check("R10 collide cnt", int'(byte_cnt_o), 0);

    // R7 without auto: early end releases buffer silently
    auto_clr_en_i = 1'b0; rdy_mode_i = 1'b0; xfer_size_i = 2'd1;
    load(2, 9);
    dma_xend_i = 1'b1;
    #1;
    check("R7 no pulse without auto", auto_clr_o, 0);
    cyc();
    dma_xend_i = 1'b0;
    check("R7 released", cause_vld_o, 0);
    check("R7 no request", clr_req_o, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule